// File: doc/BRIEF.md
# Compare-Clear Capture Timer

This block is a 16-bit up-counting timer for measuring external events. It counts on a clock taken from one of seven divided taps of the system clock or from edges on an external clock pin. Whenever the count reaches the value in the compare register, it restarts from zero and raises a timer interrupt flag. The timer therefore runs as a periodic timebase while it also measures input events.

An edge of the selected polarity on the capture pin copies the running count into a capture register and raises a separate capture flag. Software can time intervals longer than one timer period: it counts the match interrupts that occur between two captures and combines that number with the captured values.

Software reaches the block through a byte-wide register port. Writes take effect on the clock edge. Reads are combinational.

| Address | Contents |
|---|---|
| 0 | Control A: bit 7 enable, bits 5:4 mode, bits 3:2 capture polarity, bit 0 counter clear |
| 1 | Control B: bits 7:5 clock select, bit 4 timer flag (read only), bit 3 capture flag (read only), bit 2 output polarity (stored only), bit 1 external clock edge |
| 2, 3 | Compare, low byte and high byte |
| 4, 5 | Count, low byte and high byte (read only) |
| 6, 7 | Capture, low byte and high byte (read only) |

Top module: `cap_timer`

## Requirements
- R1: After reset every register at addresses 0 to 7 reads zero, and both interrupt outputs are low.
- R2: The counter runs only when enable (address 0 bit 7) is 1 and the mode field (address 0 bits 5:4) is 01. In any other setting the count holds at zero, and no match or capture event occurs.
- R3: The clock select field (address 1 bits 7:5) chooses the count rate. Codes 0 to 6 give one count every 1, 2, 4, 8, 64, 512 or 2048 system clocks. Code 7 selects the external clock pin.
- R4: On a count tick where the count equals the compare register, the count becomes zero on the next edge and the timer flag (tmr_irq, address 1 bit 4) is set.
- R5: Writing 1 to address 0 bit 0 sets the count to zero on the following edge. That bit reads 1 for exactly one cycle and then reads 0 by itself.
- R6: A qualified capture edge loads the current count into the capture register and sets the capture flag (cap_irq, address 1 bit 3). If a match occurs in the same cycle, the register receives the count from before the clear.
- R7: The capture polarity field (address 0 bits 3:2) selects the qualifying edge: 00 none, 01 falling, 10 rising, 11 both. Edges that do not qualify leave the capture register and the flag unchanged.
- R8: Each pin passes through a two-flop synchronizer and an edge detector. A capture edge on the pin takes effect on the third clock edge after the pin changes. In external clock mode, each selected edge of the clock pin gives exactly one count: rising edges when address 1 bit 1 is 0, falling edges when it is 1.
- R9: A pulse on tmr_ack clears the timer flag, and a pulse on cap_ack clears the capture flag. If a flag is set and acknowledged in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ext_clk_pin | input | 1 | External count clock (asynchronous) |
| cap_pin | input | 1 | Capture input (asynchronous) |
| tmr_ack | input | 1 | Acknowledge pulse for the timer flag |
| cap_ack | input | 1 | Acknowledge pulse for the capture flag |
| tmr_irq | output | 1 | Timer match flag |
| cap_irq | output | 1 | Capture flag |

## Verification
The assertions check the following on every cycle:
- the count steps by one on a tick, holds between ticks and clears after a match;
- the count stays at zero while the timer is stopped;
- the capture register takes the count from before any clear;
- the clear bit lasts a single cycle;
- an edge detector never reports the same edge twice;
- an acknowledge clears its flag.

Only the bench scenarios can show the following:
- the actual divide ratio of each prescaler tap;
- the three-edge latency from pin to capture;
- the capture edges that each polarity code accepts and the edges it rejects;
- the count that the external clock produces for each edge choice.

// File: rtl/ct_pkg.sv
package ct_pkg;
   localparam logic [2:0] ADR_CTRLA = 3'd0;
   localparam logic [2:0] ADR_CTRLB = 3'd1;
   localparam logic [2:0] ADR_CMPL  = 3'd2;
   localparam logic [2:0] ADR_CMPH  = 3'd3;
   localparam logic [2:0] ADR_CNTL  = 3'd4;
   localparam logic [2:0] ADR_CNTH  = 3'd5;
   localparam logic [2:0] ADR_CAPL  = 3'd6;
   localparam logic [2:0] ADR_CAPH  = 3'd7;

   localparam logic [1:0] MODE_CAPTURE = 2'b01;

   // capture polarity: bit 0 accepts falling edges, bit 1 accepts rising edges
   typedef enum logic [1:0] {
      POL_NONE = 2'b00,
      POL_FALL = 2'b01,
      POL_RISE = 2'b10,
      POL_BOTH = 2'b11
   } cap_pol_e;

   // log2 of the divide ratio of each internal prescaler tap
   function automatic int tap_shift(input int idx);
      case (idx)
         0: return 0;
         1: return 1;
         2: return 2;
         3: return 3;
         4: return 6;
         5: return 9;
         default: return 11;
      endcase
   endfunction
endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ct_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;
   assign fall = ~sync_q[STAGES-1] & prev_q;

   // R8: an edge is reported for a single cycle only
   assert_single_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   assert_single_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler
   import ct_pkg::*;
#(
   parameter int PSC_W = 11,
   parameter int SEL_W = 3,
   parameter int NTAP  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   input  logic             ext_tick,
   output logic             tick
);
   localparam int NSEL = 1 << SEL_W;

   generate
      if (NTAP > NSEL - 1) begin : g_bad_ntap
         $error("ct_prescaler: too many taps for the select width");
      end
      if (PSC_W < tap_shift(NTAP - 1)) begin : g_bad_psc
         $error("ct_prescaler: PSC_W too narrow for the slowest tap");
      end
   endgenerate

   logic [PSC_W-1:0] psc_q;
   logic [NSEL-1:0]  tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   psc_q <= '0;
      else if (run) psc_q <= psc_q + 1'b1;
      else          psc_q <= '0;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NSEL; gi++) begin : g_tap
         localparam int SH = tap_shift(gi);
         if (gi == NSEL - 1) begin : g_ext
            assign tap[gi] = ext_tick;
         end else if (gi >= NTAP) begin : g_none
            assign tap[gi] = 1'b0;
         end else if (SH == 0) begin : g_full
            assign tap[gi] = 1'b1;
         end else begin : g_div
            assign tap[gi] = &psc_q[SH-1:0];
         end
      end
   endgenerate

   assign tick = run & tap[sel];

   // R2: no tick is issued while stopped
   assert_no_tick_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);
endmodule

// File: rtl/ct_core.sv
module ct_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             sw_clr,
   input  logic [CNT_W-1:0] cmp,
   input  logic             cap_ev,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap,
   output logic             match
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("ct_core: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap_q;

   assign match = run & tick & (cnt_q == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run || sw_clr)  cnt_q <= '0;
      else if (tick)            cnt_q <= match ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (cap_ev) cap_q <= cnt_q;
   end

   assign cnt = cnt_q;
   assign cap = cap_q;

   assert_zero_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == '0);
   assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !match && !sw_clr) |=> cnt_q == $past(cnt_q) + 1'b1);
   assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick && !sw_clr) |=> $stable(cnt_q));
   assert_clear_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> cnt_q == '0);
   assert_clear_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> cnt_q == '0);
   assert_capture_pre_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev |=> cap_q == $past(cnt_q));
endmodule

// File: rtl/cap_timer.sv
module cap_timer
   import ct_pkg::*;
#(
   parameter int DW     = 8,
   parameter int PSC_W  = 11,
   parameter int SYNC_N = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [2:0]    rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          ext_clk_pin,
   input  logic          cap_pin,
   input  logic          tmr_ack,
   input  logic          cap_ack,
   output logic          tmr_irq,
   output logic          cap_irq
);
   localparam int CNT_W = 2 * DW;
   localparam int PAD_W = DW - 8;

   generate
      if (DW < 8) begin : g_bad_dw
         $error("cap_timer: DW must be at least 8");
      end
   endgenerate

   logic             en_q, clr_q, opol_q, xedge_q;
   logic [1:0]       mode_q;
   cap_pol_e         pol_q;
   logic [2:0]       sel_q;
   logic [CNT_W-1:0] cmp_q;
   logic             tmr_flag_q, cap_flag_q;

   logic             run, tick, match, cap_ev, ext_tick;
   logic             xr, xf, cr, cf;
   logic [CNT_W-1:0] cnt, cap;
   logic             wr_a;

   assign run  = en_q & (mode_q == MODE_CAPTURE);
   assign wr_a = wr_en & (wr_addr == ADR_CTRLA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         mode_q  <= 2'b00;
         pol_q   <= POL_NONE;
         clr_q   <= 1'b0;
         sel_q   <= 3'd0;
         opol_q  <= 1'b0;
         xedge_q <= 1'b0;
         cmp_q   <= '0;
      end else begin
         clr_q <= wr_a & wr_data[0];
         if (wr_a) begin
            en_q   <= wr_data[7];
            mode_q <= wr_data[5:4];
            pol_q  <= cap_pol_e'(wr_data[3:2]);
         end
         if (wr_en) begin
            case (wr_addr)
               ADR_CTRLB: begin
                  sel_q   <= wr_data[7:5];
                  opol_q  <= wr_data[2];
                  xedge_q <= wr_data[1];
               end
               ADR_CMPL: cmp_q[DW-1:0]     <= wr_data;
               ADR_CMPH: cmp_q[CNT_W-1:DW] <= wr_data;
               default: ;
            endcase
         end
      end
   end

   ct_edge_sync #(.STAGES(SYNC_N)) i_xclk_sync (
      .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin), .rise(xr), .fall(xf));

   ct_edge_sync #(.STAGES(SYNC_N)) i_cap_sync (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin), .rise(cr), .fall(cf));

   assign ext_tick = xedge_q ? xf : xr;
   assign cap_ev   = run & ((pol_q[0] & cf) | (pol_q[1] & cr));

   ct_prescaler #(.PSC_W(PSC_W), .SEL_W(3), .NTAP(7)) i_psc (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(sel_q),
      .ext_tick(ext_tick), .tick(tick));

   ct_core #(.CNT_W(CNT_W)) i_core (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .sw_clr(clr_q),
      .cmp(cmp_q), .cap_ev(cap_ev), .cnt(cnt), .cap(cap), .match(match));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_flag_q <= 1'b0;
         cap_flag_q <= 1'b0;
      end else begin
         if (match)        tmr_flag_q <= 1'b1;
         else if (tmr_ack) tmr_flag_q <= 1'b0;
         if (cap_ev)       cap_flag_q <= 1'b1;
         else if (cap_ack) cap_flag_q <= 1'b0;
      end
   end

   assign tmr_irq = tmr_flag_q;
   assign cap_irq = cap_flag_q;

   logic [7:0] ctrla_rd, ctrlb_rd;
   assign ctrla_rd = {en_q, 1'b0, mode_q, pol_q, 1'b0, clr_q};
   assign ctrlb_rd = {sel_q, tmr_flag_q, cap_flag_q, opol_q, xedge_q, 1'b0};

   generate
      if (PAD_W > 0) begin : g_pad
         always_comb begin
            case (rd_addr)
               ADR_CTRLA: rd_data = {{PAD_W{1'b0}}, ctrla_rd};
               ADR_CTRLB: rd_data = {{PAD_W{1'b0}}, ctrlb_rd};
               ADR_CMPL:  rd_data = cmp_q[DW-1:0];
               ADR_CMPH:  rd_data = cmp_q[CNT_W-1:DW];
               ADR_CNTL:  rd_data = cnt[DW-1:0];
               ADR_CNTH:  rd_data = cnt[CNT_W-1:DW];
               ADR_CAPL:  rd_data = cap[DW-1:0];
               default:   rd_data = cap[CNT_W-1:DW];
            endcase
         end
      end else begin : g_nopad
         always_comb begin
            case (rd_addr)
               ADR_CTRLA: rd_data = ctrla_rd;
               ADR_CTRLB: rd_data = ctrlb_rd;
               ADR_CMPL:  rd_data = cmp_q[DW-1:0];
               ADR_CMPH:  rd_data = cmp_q[CNT_W-1:DW];
               ADR_CNTL:  rd_data = cnt[DW-1:0];
               ADR_CNTH:  rd_data = cnt[CNT_W-1:DW];
               ADR_CAPL:  rd_data = cap[DW-1:0];
               default:   rd_data = cap[CNT_W-1:DW];
            endcase
         end
      end
   endgenerate

   assert_no_events_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !match && !cap_ev);
   assert_clear_self_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_q && !(wr_a && wr_data[0])) |=> !clr_q);
   assert_match_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> tmr_irq);
   assert_capture_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev |=> cap_irq);
   assert_ack_clears_tmr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_ack && !match) |=> !tmr_irq);
   assert_ack_clears_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ack && !cap_ev) |=> !cap_irq);
endmodule

// File: tb/test_cap_timer.sv
module test_cap_timer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       ext_clk_pin = 1'b0;
   logic       cap_pin = 1'b0;
   logic       tmr_ack = 1'b0;
   logic       cap_ack = 1'b0;
   logic       tmr_irq, cap_irq;

   int checks = 0;
   int fails  = 0;

   cap_timer i_cap_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin), .tmr_ack(tmr_ack),
      .cap_ack(cap_ack), .tmr_irq(tmr_irq), .cap_irq(cap_irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd8(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic rd16(input logic [2:0] a, output int v);
      logic [7:0] lo, hi;
      rd8(a, lo); rd8(a + 3'd1, hi);
      v = {16'd0, hi, lo};
   endtask

   // control A byte: enable, mode 01, polarity, clear
   task automatic ctl_a(input bit en, input logic [1:0] pol, input bit clr);
      wr(3'd0, {en, 1'b0, 2'b01, pol, 1'b0, clr});
   endtask

   task automatic set_cmp(input int v);
      wr(3'd2, v[7:0]); wr(3'd3, v[15:8]);
   endtask

   task automatic ack_all();
      tmr_ack = 1'b1; cap_ack = 1'b1; @(negedge clk);
      tmr_ack = 1'b0; cap_ack = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 8; a++) begin
         rd8(a[2:0], d);
         chk(d == 8'h00, "R1 register reset", d, 0);
      end
      chk(!tmr_irq && !cap_irq, "R1 irq reset", {tmr_irq, cap_irq}, 0);
   endtask

   task automatic t_disabled();
      int v;
      wr(3'd1, 8'h00); set_cmp(16'hFFFF);
      ctl_a(1'b0, 2'b00, 1'b0); step(20); rd16(3'd4, v);
      chk(v == 0, "R2 held at zero when disabled", v, 0);
      wr(3'd0, 8'h80); step(20); rd16(3'd4, v);
      chk(v == 0, "R2 held at zero in other mode", v, 0);
      chk(!tmr_irq && !cap_irq, "R2 no events", {tmr_irq, cap_irq}, 0);
   endtask

   task automatic t_div(input int sel, input int ratio);
      int c0, c1, n;
      ctl_a(1'b0, 2'b00, 1'b0);
      wr(3'd1, {sel[2:0], 5'b0});
      ctl_a(1'b1, 2'b00, 1'b0);
      rd16(3'd4, c0);
      for (int g = 0; g < 5000; g++) begin
         step(1); rd16(3'd4, c1);
         if (c1 != c0) break;
      end
      c0 = c1; n = 0;
      for (int g = 0; g < 5000; g++) begin
         step(1); n++; rd16(3'd4, c1);
         if (c1 != c0) break;
      end
      chk(n == ratio, "R3 prescaler ratio", n, ratio);
   endtask

   task automatic t_match();
      int v;
      ctl_a(1'b0, 2'b00, 1'b0);
      ack_all();
      wr(3'd1, 8'h00); set_cmp(5);
      ctl_a(1'b1, 2'b00, 1'b0);
      for (int g = 0; g < 50; g++) begin
         rd16(3'd4, v);
         if (v == 5) break;
         step(1);
      end
      chk(v == 5 && !tmr_irq, "R4 reaches compare without flag", v, 5);
      step(1); rd16(3'd4, v);
      chk(v == 0, "R4 clear after match", v, 0);
      chk(tmr_irq == 1'b1, "R4 timer flag set", tmr_irq, 1);
      ctl_a(1'b0, 2'b00, 1'b0);
      chk(tmr_irq == 1'b1, "R9 flag held while stopped", tmr_irq, 1);
      tmr_ack = 1'b1; step(1); tmr_ack = 1'b0;
      chk(tmr_irq == 1'b0, "R9 ack clears timer flag", tmr_irq, 0);
   endtask

   task automatic t_swclr();
      int v;
      logic [7:0] d;
      set_cmp(16'hFFFF);
      ctl_a(1'b1, 2'b00, 1'b0);
      step(20);
      rd16(3'd4, v);
      chk(v > 10, "R5 counting before clear", v, 11);
      ctl_a(1'b1, 2'b00, 1'b1);
      rd8(3'd0, d);
      chk(d[0] == 1'b1, "R5 clear bit visible one cycle", d[0], 1);
      step(1);
      rd16(3'd4, v); rd8(3'd0, d);
      chk(v == 0, "R5 count cleared", v, 0);
      chk(d[0] == 1'b0, "R5 clear bit self-clears", d[0], 0);
   endtask

   // drive the capture pin and expect a capture of the count read at the drive time + 2
   task automatic cap_edge_hit(input logic lvl, input string req);
      int c0, v;
      rd16(3'd4, c0);
      cap_pin = lvl;
      step(3);
      rd16(3'd6, v);
      chk(v == c0 + 2, req, v, c0 + 2);
      chk(cap_irq == 1'b1, req, cap_irq, 1);
      ack_all();
   endtask

   task automatic cap_edge_miss(input logic lvl, input string req);
      int c0, v;
      rd16(3'd6, c0);
      cap_pin = lvl;
      step(6);
      rd16(3'd6, v);
      chk(v == c0 && !cap_irq, req, v, c0);
   endtask

   task automatic t_capture();
      set_cmp(16'hFFFF);
      ctl_a(1'b1, 2'b10, 1'b1);
      step(4);
      cap_edge_hit(1'b1, "R6 rising capture");
      cap_edge_miss(1'b0, "R7 falling ignored when rising only");
      ctl_a(1'b1, 2'b01, 1'b0);
      cap_edge_miss(1'b1, "R7 rising ignored when falling only");
      cap_edge_hit(1'b0, "R7 falling capture");
      ctl_a(1'b1, 2'b11, 1'b0);
      cap_edge_hit(1'b1, "R7 both edges rising");
      cap_edge_hit(1'b0, "R7 both edges falling");
      ctl_a(1'b1, 2'b00, 1'b0);
      cap_edge_miss(1'b1, "R7 none ignores rise");
      cap_edge_miss(1'b0, "R7 none ignores fall");
   endtask

   task automatic t_cap_match();
      int v;
      ctl_a(1'b0, 2'b10, 1'b0);
      ack_all();
      set_cmp(40);
      ctl_a(1'b1, 2'b10, 1'b0);
      for (int g = 0; g < 100; g++) begin
         rd16(3'd4, v);
         if (v == 38) break;
         step(1);
      end
      cap_pin = 1'b1;
      step(3);
      rd16(3'd6, v);
      chk(v == 40, "R6 capture takes pre-clear count", v, 40);
      rd16(3'd4, v);
      chk(v == 0, "R4 cleared in capture cycle", v, 0);
      chk(tmr_irq && cap_irq, "R6 both flags set", {tmr_irq, cap_irq}, 3);
      cap_pin = 1'b0;
      ack_all();
   endtask

   task automatic pulse_ext(input int n);
      for (int i = 0; i < n; i++) begin
         ext_clk_pin = 1'b1; step(3);
         ext_clk_pin = 1'b0; step(3);
      end
   endtask

   task automatic t_ext();
      int v;
      ctl_a(1'b0, 2'b00, 1'b0);
      set_cmp(16'hFFFF);
      wr(3'd1, 8'hE0);
      ctl_a(1'b1, 2'b00, 1'b0);
      step(10); rd16(3'd4, v);
      chk(v == 0, "R8 no count without external edges", v, 0);
      pulse_ext(5); step(4); rd16(3'd4, v);
      chk(v == 5, "R8 rising external edges", v, 5);
      wr(3'd1, 8'hE2);
      ctl_a(1'b1, 2'b00, 1'b1);
      step(2); rd16(3'd4, v);
      chk(v == 0, "R5 clear before falling test", v, 0);
      ext_clk_pin = 1'b1; step(5); rd16(3'd4, v);
      chk(v == 0, "R8 rising edge ignored in falling mode", v, 0);
      ext_clk_pin = 1'b0; step(4);
      pulse_ext(2); step(4); rd16(3'd4, v);
      chk(v == 3, "R8 falling external edges", v, 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_disabled();
      t_div(0, 1);
      t_div(1, 2);
      t_div(3, 8);
      t_div(4, 64);
      t_div(6, 2048);
      t_match();
      wr(3'd1, 8'h00);
      t_swclr();
      t_capture();
      t_cap_match();
      t_ext();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule